// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace words into an on-chip circular memory while capture is switched on. Every accepted word first lands in a one-stage holding register. On the next clock it is written at the write pointer, and the pointer then advances modulo the depth. When the pointer wraps for the first time, a sticky Full flag is raised. Once a word flagged as the trigger has been stored, a post-trigger counter decrements for each later word. When that counter reaches zero the block raises AcquisitionComplete and stops storing, so the memory holds a window of trace around the trigger event.

A host works the block through a parallel register port with a 3-bit select, separate read and write strobes and 32-bit data. Read data is registered and is valid on the clock after the read strobe. To prepare a capture, the host clears the write pointer, loads the post-trigger count and then enables capture. After capture it waits for FormatterEmpty, then reads the status and the write pointer to work out where the oldest word is. It sets the read pointer and streams the words out through the auto-incrementing data register. In narrow mode only the lower half of each trace word is kept. In wide mode the full word is stored.

Register select codes: 0 control, 1 status, 2 depth, 3 width, 4 read pointer, 5 write pointer, 6 post-trigger count, 7 RAM data. Control bit 0 is enable and bit 1 is wide mode. Status bit 0 is Full, bit 1 is Triggered, bit 2 is AcquisitionComplete and bit 3 is FormatterEmpty.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, control, both pointers and the post-trigger count read 0, and status reads 0x8 (only FormatterEmpty set).
- R2: Select 2 returns the memory depth in words and select 3 returns the stored word width in bits; both are read-only.
- R3: While control bit 0 is 1, each cycle with trace_valid high stores one word at the write pointer, which then advances by one. Words offered while bit 0 is 0 are not stored. A word accepted in the cycle that capture is switched off is still written.
- R4: With control bit 1 at 1 the whole word is stored. With bit 1 at 0 the upper half of the stored word is zero and the lower half is kept.
- R5: The write pointer wraps from depth-1 to 0. The first wrap sets status bit 0 (Full), which stays set until the write pointer register is written.
- R6: Storing a word that has trace_trigger set raises status bit 1 (Triggered). Each word stored after that decrements the post-trigger count, down to a floor of 0.
- R7: When the post-trigger count reaches 0 after the trigger, status bit 2 (AcquisitionComplete) rises. From then on no word is stored and the write pointer is frozen.
- R8: If the post-trigger count is 0 when the trigger word is stored, AcquisitionComplete rises with that word.
- R9: A read of select 7 returns the word at the read pointer, then the read pointer advances by one and wraps modulo the depth.
- R10: A write to select 7 stores the data at the read pointer, then the read pointer advances by one.
- R11: Status bit 3 (FormatterEmpty) is 0 exactly while a word waits in the holding register, and 1 otherwise.
- R12: A control write with bit 0 set clears Triggered and AcquisitionComplete. A write-pointer write clears Full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_valid | input | 1 | Trace word offered this cycle |
| trace_word | input | WORD_W | Trace word |
| trace_trigger | input | 1 | Offered word is the trigger event |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |

## Verification
- **Trace words:** A word offered at one clock edge sits in the holding register for one cycle and is written at the next edge. The bench therefore reads the write pointer, the status and the memory only after that second edge.
- **Register port:** Register writes take effect at the edge on which they are presented. Read data appears on reg_rdata one edge after the strobe, so every read task samples it at the falling edge that follows.
- **FormatterEmpty low:** To see FormatterEmpty at 0, the bench holds a status read across both edges of a single trace word. The value captured at the second edge shows the word still pending.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_DEPTH  = 3'd2,
        SEL_WIDTH  = 3'd3,
        SEL_RPTR   = 3'd4,
        SEL_WPTR   = 3'd5,
        SEL_TCOUNT = 3'd6,
        SEL_DATA   = 3'd7
    } reg_sel_e;

    // bit 0 enable, bit 1 wide mode
    typedef struct packed {
        logic wide;
        logic enable;
    } ctrl_t;

    // bit 0 full ... bit 3 formatter empty
    typedef struct packed {
        logic fmt_empty;
        logic acq_done;
        logic triggered;
        logic full;
    } status_t;

    function automatic logic [REG_W-1:0] status_word(status_t s);
        return REG_W'(s);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        return REG_W'(c);
    endfunction

endpackage

// File: rtl/tcb_input_stage.sv
module tcb_input_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wide,
    input  logic              stop,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_trig,
    output logic              hold_vld,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_trig
);
    localparam int HALF_W = WORD_W / 2;

    logic              accept;
    logic [WORD_W-1:0] shaped;

    assign accept = enable & in_valid & ~stop;
    assign shaped = wide ? in_word
                         : {{(WORD_W-HALF_W){1'b0}}, in_word[HALF_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld  <= 1'b0;
            hold_word <= '0;
            hold_trig <= 1'b0;
        end else begin
            hold_vld <= accept;
            if (accept) begin
                hold_word <= shaped;
                hold_trig <= in_trig;
            end
        end
    end

    // R7: once capture is stopping, nothing new enters the holding stage
    a_r7_stop_blocks_input: assert property (@(posedge clk) disable iff (rst)
        stop |=> !hold_vld);

    // R3: a disabled block takes no word
    a_r3_disabled_ignores: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !hold_vld);

endmodule

// File: rtl/tcb_capture_ctrl.sv
module tcb_capture_ctrl
    import tcb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_vld,
    input  logic              hold_trig,
    input  logic              wptr_load,
    input  logic [ADDR_W-1:0] wptr_val,
    input  logic              tcnt_load,
    input  logic [REG_W-1:0]  tcnt_val,
    input  logic              rearm,
    output logic [ADDR_W-1:0] wptr,
    output logic              full,
    output logic              triggered,
    output logic              acq_done,
    output logic [REG_W-1:0]  tcount,
    output logic              store_en,
    output logic              stop
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic finish_now;
    logic cnt_low;

    assign store_en   = hold_vld & ~acq_done;
    assign cnt_low    = (tcount == '0) | (tcount == REG_W'(1));
    assign finish_now = store_en &
                        ((triggered & cnt_low) |
                         (~triggered & hold_trig & (tcount == '0)));
    assign stop       = acq_done | finish_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            full <= 1'b0;
        end else if (wptr_load) begin
            wptr <= wptr_val;
            full <= 1'b0;
        end else if (store_en) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (wptr == LAST) full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            triggered <= 1'b0;
            acq_done  <= 1'b0;
        end else if (rearm) begin
            triggered <= 1'b0;
            acq_done  <= 1'b0;
        end else begin
            if (store_en & hold_trig) triggered <= 1'b1;
            if (finish_now)           acq_done  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tcount <= '0;
        else if (tcnt_load)
            tcount <= tcnt_val;
        else if (store_en & triggered & (tcount != '0))
            tcount <= tcount - 1'b1;
    end

    a_r7_done_after_trigger: assert property (@(posedge clk) disable iff (rst)
        acq_done |-> triggered);

    a_r7_pointer_frozen: assert property (@(posedge clk) disable iff (rst)
        (acq_done && !wptr_load) |=> $stable(wptr));

    a_r6_trigger_sticky: assert property (@(posedge clk) disable iff (rst)
        (triggered && !rearm) |=> triggered);

    a_r5_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (full && !wptr_load) |=> full);

endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              host_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // host port wins on an address collision
    always_ff @(posedge clk) begin
        if (host_en)
            mem[host_addr] <= host_data;
        if (cap_en && !(host_en && host_addr == cap_addr))
            mem[cap_addr] <= cap_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
    import tcb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trace_valid,
    input  logic [WORD_W-1:0] trace_word,
    input  logic              trace_trigger,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int ADDR_W = $clog2(DEPTH);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    status_t           status;
    logic [ADDR_W-1:0] rptr, wptr;
    logic [REG_W-1:0]  tcount, rd_mux;
    logic              hold_vld, hold_trig;
    logic [WORD_W-1:0] hold_word, mem_rd;
    logic              full, triggered, acq_done, store_en, stop;
    logic              wr_ctrl, wr_rptr, wr_wptr, wr_tcnt, wr_data, rd_data, rearm;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_ctrl = reg_wr & (sel == SEL_CTRL);
    assign wr_rptr = reg_wr & (sel == SEL_RPTR);
    assign wr_wptr = reg_wr & (sel == SEL_WPTR);
    assign wr_tcnt = reg_wr & (sel == SEL_TCOUNT);
    assign wr_data = reg_wr & (sel == SEL_DATA);
    assign rd_data = reg_rd & (sel == SEL_DATA);
    assign rearm   = wr_ctrl & reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= ctrl_t'(reg_wdata[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rptr <= '0;
        else if (wr_rptr)
            rptr <= reg_wdata[ADDR_W-1:0];
        else if (wr_data | rd_data)
            rptr <= (rptr == ADDR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end

    tcb_input_stage #(.WORD_W(WORD_W)) u_input (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.enable),
        .wide      (ctrl.wide),
        .stop      (stop),
        .in_valid  (trace_valid),
        .in_word   (trace_word),
        .in_trig   (trace_trigger),
        .hold_vld  (hold_vld),
        .hold_word (hold_word),
        .hold_trig (hold_trig)
    );

    tcb_capture_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .hold_vld  (hold_vld),
        .hold_trig (hold_trig),
        .wptr_load (wr_wptr),
        .wptr_val  (reg_wdata[ADDR_W-1:0]),
        .tcnt_load (wr_tcnt),
        .tcnt_val  (reg_wdata),
        .rearm     (rearm),
        .wptr      (wptr),
        .full      (full),
        .triggered (triggered),
        .acq_done  (acq_done),
        .tcount    (tcount),
        .store_en  (store_en),
        .stop      (stop)
    );

    tcb_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
        .clk       (clk),
        .cap_en    (store_en),
        .cap_addr  (wptr),
        .cap_data  (hold_word),
        .host_en   (wr_data),
        .host_addr (rptr),
        .host_data (reg_wdata[WORD_W-1:0]),
        .rd_addr   (rptr),
        .rd_data   (mem_rd)
    );

    assign status = '{fmt_empty: ~hold_vld, acq_done: acq_done,
                      triggered: triggered, full: full};

    always_comb begin
        unique case (sel)
            SEL_CTRL:   rd_mux = ctrl_word(ctrl);
            SEL_STATUS: rd_mux = status_word(status);
            SEL_DEPTH:  rd_mux = REG_W'(DEPTH);
            SEL_WIDTH:  rd_mux = REG_W'(WORD_W);
            SEL_RPTR:   rd_mux = REG_W'(rptr);
            SEL_WPTR:   rd_mux = REG_W'(wptr);
            SEL_TCOUNT: rd_mux = tcount;
            SEL_DATA:   rd_mux = REG_W'(mem_rd);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    // R9: each RAM-data read moves the read pointer on by exactly one
    a_r9_rptr_step: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !reg_wr) |=> (rptr == ADDR_W'($past(rptr) + 1'b1)));

    // R11: a pending word is always drained on the next edge
    a_r11_drain: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && !acq_done) |=> (wptr != $past(wptr) || $past(wr_wptr)));

endmodule

// File: tb/test_trace_capture_buffer.sv
`timescale 1ns/1ps
module test_trace_capture_buffer;

    localparam int DEPTH = 16;
    localparam int WW    = 32;
    localparam logic [2:0] S_CTRL = 3'd0, S_STAT = 3'd1, S_DEPTH = 3'd2,
                           S_WIDTH = 3'd3, S_RPTR = 3'd4, S_WPTR = 3'd5,
                           S_TCNT = 3'd6, S_DATA = 3'd7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trace_valid = 1'b0;
    logic [WW-1:0] trace_word = '0;
    logic          trace_trigger = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model
    logic [31:0] exp_mem [DEPTH];
    int          e_wptr = 0;
    int          e_tcnt = 0;
    bit          e_full = 0, e_trig = 0, e_done = 0, e_en = 0, e_wide = 0;

    trace_capture_buffer #(.DEPTH(DEPTH), .WORD_W(WW)) i_trace_capture_buffer (
        .clk(clk), .rst(rst), .trace_valid(trace_valid), .trace_word(trace_word),
        .trace_trigger(trace_trigger), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] shape(input logic [31:0] w);
        return e_wide ? w : {16'h0, w[15:0]};
    endfunction

    function automatic int status_exp();
        return {28'h0, 1'b1, e_done, e_trig, e_full};
    endfunction

    // model of one stored word
    task automatic model_store(input logic [31:0] w, input bit trig);
        if (!e_en || e_done) return;
        exp_mem[e_wptr] = shape(w);
        if (e_wptr == DEPTH - 1) e_full = 1;
        e_wptr = (e_wptr + 1) % DEPTH;
        if (e_trig) begin
            if (e_tcnt <= 1) e_done = 1;
            if (e_tcnt != 0) e_tcnt--;
        end else if (trig) begin
            e_trig = 1;
            if (e_tcnt == 0) e_done = 1;
        end
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (s == S_CTRL) begin
            e_en = d[0]; e_wide = d[1];
            if (d[0]) begin e_trig = 0; e_done = 0; end
        end
        if (s == S_WPTR) begin e_wptr = int'(d) % DEPTH; e_full = 0; end
        if (s == S_TCNT) e_tcnt = int'(d);
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] w, input bit trig);
        @(negedge clk);
        trace_valid = 1'b1; trace_word = w; trace_trigger = trig;
        @(negedge clk);
        trace_valid = 1'b0; trace_trigger = 1'b0; trace_word = 32'hBAD0BAD0;
        model_store(w, trig);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(S_CTRL, v);  check("R1 ctrl", v, 0);
        reg_read(S_STAT, v);  check("R1 status", v, 32'h8);
        reg_read(S_RPTR, v);  check("R1 rptr", v, 0);
        reg_read(S_WPTR, v);  check("R1 wptr", v, 0);
        reg_read(S_TCNT, v);  check("R1 tcount", v, 0);
        // R2 identification
        reg_read(S_DEPTH, v); check("R2 depth", v, DEPTH);
        reg_read(S_WIDTH, v); check("R2 width", v, WW);
        reg_write(S_DEPTH, 32'h55); reg_read(S_DEPTH, v); check("R2 depth read-only", v, DEPTH);

        // R3 disabled input ignored
        push(32'h11111111, 1'b0);
        reg_read(S_WPTR, v); check("R3 disabled no store", v, 0);

        // wide capture, post-trigger count 5
        reg_write(S_TCNT, 5);
        reg_write(S_WPTR, 0);
        reg_write(S_CTRL, 3);
        reg_read(S_CTRL, v); check("R3 ctrl readback", v, 3);
        for (int i = 0; i < 17; i++) begin
            push(32'h1000_0000 + i * 32'h0102_0304, 1'b0);
            if (i % 3 == 0) repeat (2) @(negedge clk);
            if (i == 2) begin reg_read(S_WPTR, v); check("R3 wptr advance", v, 3); end
        end
        reg_read(S_WPTR, v); check("R5 wptr wrap", v, e_wptr);
        reg_read(S_STAT, v); check("R5 full set", v, 32'h9);

        push(32'hFEED_0017, 1'b1);
        reg_read(S_STAT, v); check("R6 triggered", v, status_exp());
        reg_read(S_TCNT, v); check("R6 count at trigger", v, 5);
        for (int i = 0; i < 4; i++) push(32'h2000_0000 + i, 1'b0);
        reg_read(S_TCNT, v); check("R6 count decrement", v, 1);
        reg_read(S_STAT, v); check("R6 not yet complete", v, 32'hB);
        push(32'h3000_0000, 1'b0);
        reg_read(S_STAT, v); check("R7 complete", v, 32'hF);
        for (int i = 0; i < 3; i++) push(32'h4000_0000 + i, 1'b0);
        reg_read(S_WPTR, v); check("R7 wptr frozen", v, 7);
        check("R7 model wptr", 32'(e_wptr), 7);

        // R9 readout from oldest word
        reg_write(S_RPTR, e_wptr);
        for (int i = 0; i < DEPTH; i++) begin
            reg_read(S_DATA, v);
            check("R9 data readout", v, exp_mem[(7 + i) % DEPTH]);
        end
        reg_read(S_RPTR, v); check("R9 rptr wrap", v, 7);

        // narrow mode, count 0: R12 rearm, R8, R4
        reg_write(S_WPTR, 0);
        reg_write(S_TCNT, 0);
        reg_write(S_CTRL, 1);
        reg_read(S_STAT, v); check("R12 rearm clears", v, 32'h8);
        push(32'hDEADBEEF, 1'b0);
        push(32'h13572468, 1'b1);
        reg_read(S_STAT, v); check("R8 complete on trigger", v, 32'hE);
        reg_read(S_WPTR, v); check("R8 wptr", v, 2);
        reg_write(S_RPTR, 0);
        reg_read(S_DATA, v); check("R4 narrow word0", v, 32'h0000BEEF);
        reg_read(S_DATA, v); check("R4 narrow word1", v, 32'h00002468);

        // R10 host writes with wrap
        reg_write(S_RPTR, 15);
        reg_write(S_DATA, 32'h12345678); exp_mem[15] = 32'h12345678;
        reg_write(S_DATA, 32'hCAFEF00D); exp_mem[0]  = 32'hCAFEF00D;
        reg_read(S_RPTR, v); check("R10 rptr advance", v, 1);
        reg_write(S_RPTR, 15);
        reg_read(S_DATA, v); check("R10 write word0", v, 32'h12345678);
        reg_read(S_DATA, v); check("R10 write word1", v, 32'hCAFEF00D);

        // R11 formatter empty low while pending
        reg_write(S_TCNT, 3);
        reg_write(S_CTRL, 1);
        @(negedge clk);
        trace_valid = 1'b1; trace_word = 32'h0F0F0F0F; reg_sel = S_STAT; reg_rd = 1'b1;
        @(negedge clk);
        trace_valid = 1'b0;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R11 pending not empty", reg_rdata & 32'h8, 0);
        model_store(32'h0F0F0F0F, 1'b0);
        reg_read(S_STAT, v); check("R11 empty after drain", v, 32'h8);

        // R3 word accepted as capture switches off still lands
        @(negedge clk);
        trace_valid = 1'b1; trace_word = 32'h77778888;
        reg_sel = S_CTRL; reg_wdata = 0; reg_wr = 1'b1;
        @(negedge clk);
        trace_valid = 1'b0; reg_wr = 1'b0;
        model_store(32'h77778888, 1'b0);
        e_en = 0;
        push(32'h99999999, 1'b0);
        reg_read(S_WPTR, v); check("R3 drain then ignore", v, 4);
        reg_write(S_RPTR, 2);
        reg_read(S_DATA, v); check("R11 drained word0", v, 32'h00000F0F);
        reg_read(S_DATA, v); check("R3 drained word1", v, 32'h00008888);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule